// File: doc/BRIEF.md
# Receive Mailbox Bank with Overwrite Protection

This block holds a bank of message mailboxes that collect frames delivered by a protocol engine. A frame arrives as a 32-bit identifier word, a 5-bit control word and eight data bytes, and is valid for one clock cycle. Every mailbox that is enabled and set for reception compares the identifier against its own stored identifier. It can apply its own acceptance mask while doing so. Of the mailboxes that accept the frame and are able to take it, the one with the highest number stores it. The store also captures the value of a free-running network time counter.

Each mailbox has a pending flag, a lost flag and an overwrite-protection bit. A protected mailbox that still holds an unread frame is skipped, and the frame falls through to the next accepting mailbox below it. An unprotected mailbox is simply overwritten and reports the loss. Software can therefore chain several mailboxes into a receive FIFO: every mailbox but the lowest is protected, and the lowest unprotected one flags overflow.

A word-addressed host port configures the bank. The same port reads the stored frames and timestamps and clears the flags by writing ones.

Top module: `rxmb_bank`

## Requirements
- R1: Only a mailbox whose enable bit (global word 0x000) and direction bit (global word 0x001) are both 1 is a receive candidate. A frame that matches only non-candidates changes no state.
- R2: Acceptance compares identifier bits 31 and 28..0. When bit 30 of the mailbox identifier word is 1, a 1 in the mailbox mask word (field 1) marks that bit position as don't-care. When bit 30 is 0, every compared bit must be equal. Bits 30 and 29 of the stored identifier are configuration and are kept on a store, while the other bits take the received values.
- R3: When several mailboxes can store a frame, the highest-numbered one stores it, and only that one does.
- R4: A mailbox whose protection bit (global word 0x002) is 1 and whose pending bit is 1 is not overwritten. The frame goes to the next lower accepting mailbox that can store it.
- R5: A store into an unprotected mailbox whose pending bit is already 1 sets that mailbox's lost bit (global word 0x004).
- R6: A frame that no candidate can store is dropped: pending, lost and all mailbox contents stay unchanged.
- R7: A store sets the mailbox's pending bit (global word 0x003). Writing a 1 to a pending bit clears it and also clears the same lost bit. Writing a 1 to a lost bit clears only that lost bit. Zeros written to either word have no effect.
- R8: The network time counter is 0 during reset and increases by one every clock after reset. It can be read at global word 0x005. A store writes the counter value of its storing cycle into the mailbox timestamp (field 5).
- R9: Stored content reads back as follows: the control word at field 2, with the remote-request flag at bit 4 and the length code at bits 3..0; data bytes 0..3 at field 3 and bytes 4..7 at field 4, with byte 0 in bits 31..24 (rx_data[63:56] is byte 0); the identifier at field 0. Mailbox n, field f is at word address 0x100 + 8n + f.
- R10: When a store and a pending clear hit the same mailbox in the same cycle, the store wins: the pending bit ends at 1. Candidate selection uses the flags as they were before that cycle.
- R11: After reset, every register and every mailbox word reads as zero.
- R12: host_rdata shows the word addressed in the previous cycle. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Received frame present this cycle |
| rx_id | input | 32 | Received identifier word (bit 31 extended format) |
| rx_ctrl | input | 5 | Remote-request flag [4] and length code [3:0] |
| rx_data | input | 64 | Data bytes, byte 0 in [63:56] |
| host_addr | input | 9 | Word address for read and write |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, one cycle after the address |

## Verification
Two functions can fall in the same cycle: a frame store and a host write of ones to the pending word, possibly aimed at the very mailbox the store selects. The bench provokes this with a combined task that drives a frame and a pending clear in the same cycle, both directed and at random, while a chained FIFO of protected mailboxes above one unprotected mailbox is filling. The bench model picks the target from the flags as they stood before the cycle, applies the clear, and then applies the store. It judges the result by reading back the pending and lost words and the stored mailbox.

// File: rtl/rxmb_pkg.sv
package rxmb_pkg;

    localparam int ID_W   = 32;
    localparam int CTRL_W = 5;
    localparam int DATA_W = 64;
    localparam int REG_W  = 32;

    // identifier word bit that switches on masked comparison
    localparam int ID_MASK_EN_BIT = 30;
    // identifier bits owned by configuration, never taken from a frame
    localparam logic [ID_W-1:0] ID_CFG_BITS = 32'h6000_0000;
    localparam logic [ID_W-1:0] ID_CMP_BITS = ~ID_CFG_BITS;

    typedef enum logic [2:0] {
        FLD_ID    = 3'd0,
        FLD_MASK  = 3'd1,
        FLD_CTRL  = 3'd2,
        FLD_DLO   = 3'd3,
        FLD_DHI   = 3'd4,
        FLD_STAMP = 3'd5
    } mb_field_e;

    typedef enum logic [2:0] {
        GR_ENABLE  = 3'd0,
        GR_DIR     = 3'd1,
        GR_PROTECT = 3'd2,
        GR_PENDING = 3'd3,
        GR_LOST    = 3'd4,
        GR_TIME    = 3'd5
    } glob_reg_e;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [CTRL_W-1:0] ctrl;
        logic [DATA_W-1:0] data;
    } rx_frame_t;

    function automatic logic id_accepts(logic [ID_W-1:0] mb_id,
                                        logic [ID_W-1:0] mb_mask,
                                        logic [ID_W-1:0] rx_id);
        logic [ID_W-1:0] care;
        care = ID_CMP_BITS & (mb_id[ID_MASK_EN_BIT] ? ~mb_mask : {ID_W{1'b1}});
        return ((mb_id ^ rx_id) & care) == '0;
    endfunction

    function automatic logic [ID_W-1:0] merge_id(logic [ID_W-1:0] old_id,
                                                 logic [ID_W-1:0] rx_id);
        return (old_id & ID_CFG_BITS) | (rx_id & ID_CMP_BITS);
    endfunction

endpackage

// File: rtl/rxmb_nettime.sv
module rxmb_nettime #(
    parameter int TIME_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    output logic [TIME_W-1:0] now
);
    always_ff @(posedge clk) begin
        if (rst) now <= '0;
        else     now <= now + 1'b1;
    end
endmodule

// File: rtl/rxmb_accept.sv
module rxmb_accept import rxmb_pkg::*; #(
    parameter int NUM_MB = 32
) (
    input  logic              rx_valid,
    input  logic [ID_W-1:0]   rx_id,
    input  logic [NUM_MB-1:0] enable,
    input  logic [NUM_MB-1:0] dir_rx,
    input  logic [ID_W-1:0]   mb_id   [NUM_MB],
    input  logic [ID_W-1:0]   mb_mask [NUM_MB],
    output logic [NUM_MB-1:0] cand
);
    for (genvar g = 0; g < NUM_MB; g++) begin : g_cmp
        assign cand[g] = rx_valid & enable[g] & dir_rx[g]
                       & id_accepts(mb_id[g], mb_mask[g], rx_id);
    end
endmodule

// File: rtl/rxmb_pick.sv
module rxmb_pick #(
    parameter int NUM_MB = 32
) (
    input  logic [NUM_MB-1:0] req,
    output logic [NUM_MB-1:0] grant,
    output logic              any
);
    // highest-numbered request wins
    always_comb begin
        grant = '0;
        for (int i = 0; i < NUM_MB; i++) begin
            if (req[i]) grant = NUM_MB'(1) << i;
        end
        any = |req;
    end
endmodule

// File: rtl/rxmb_flags.sv
module rxmb_flags #(
    parameter int NUM_MB = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              store_en,
    input  logic [NUM_MB-1:0] grant,
    input  logic [NUM_MB-1:0] protect,
    input  logic [NUM_MB-1:0] pend_clr,
    input  logic [NUM_MB-1:0] lost_clr,
    output logic [NUM_MB-1:0] pending,
    output logic [NUM_MB-1:0] lost
);
    logic [NUM_MB-1:0] set_v;
    logic [NUM_MB-1:0] lost_set;

    assign set_v    = store_en ? grant : '0;
    assign lost_set = set_v & pending & ~protect;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= '0;
            lost    <= '0;
        end else begin
            pending <= (pending & ~pend_clr) | set_v;
            lost    <= (lost & ~lost_clr & ~pend_clr) | lost_set;
        end
    end
endmodule

// File: rtl/rxmb_bank.sv
module rxmb_bank import rxmb_pkg::*; #(
    parameter  int NUM_MB = 32,
    parameter  int TIME_W = 32,
    localparam int IDX_W  = (NUM_MB > 1) ? $clog2(NUM_MB) : 1,
    localparam int ADDR_W = IDX_W + 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [ID_W-1:0]   rx_id,
    input  logic [CTRL_W-1:0] rx_ctrl,
    input  logic [DATA_W-1:0] rx_data,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic [REG_W-1:0]  host_wdata,
    output logic [REG_W-1:0]  host_rdata
);
    // address decode
    logic             is_mb;
    logic             glob_hit;
    logic [IDX_W-1:0] a_idx;
    mb_field_e        mfld;
    glob_reg_e        gfld;

    assign is_mb    = host_addr[ADDR_W-1];
    assign a_idx    = host_addr[ADDR_W-2:3];
    assign glob_hit = !is_mb && (a_idx == '0);
    assign mfld     = mb_field_e'(host_addr[2:0]);
    assign gfld     = glob_reg_e'(host_addr[2:0]);

    logic glob_wr;
    assign glob_wr = host_wr && glob_hit;

    // configuration vectors
    logic [NUM_MB-1:0] en_q, dir_q, prot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            dir_q  <= '0;
            prot_q <= '0;
        end else if (glob_wr) begin
            if (gfld == GR_ENABLE)  en_q   <= host_wdata[NUM_MB-1:0];
            if (gfld == GR_DIR)     dir_q  <= host_wdata[NUM_MB-1:0];
            if (gfld == GR_PROTECT) prot_q <= host_wdata[NUM_MB-1:0];
        end
    end

    logic [NUM_MB-1:0] pend_clr, lost_clr;
    assign pend_clr = (glob_wr && gfld == GR_PENDING) ? host_wdata[NUM_MB-1:0] : '0;
    assign lost_clr = (glob_wr && gfld == GR_LOST)    ? host_wdata[NUM_MB-1:0] : '0;

    // network time
    logic [TIME_W-1:0] now;

    rxmb_nettime #(.TIME_W(TIME_W)) u_time (
        .clk (clk),
        .rst (rst),
        .now (now)
    );

    // mailbox storage views
    logic [ID_W-1:0]   id_arr    [NUM_MB];
    logic [ID_W-1:0]   mask_arr  [NUM_MB];
    logic [CTRL_W-1:0] ctrl_arr  [NUM_MB];
    logic [DATA_W-1:0] data_arr  [NUM_MB];
    logic [TIME_W-1:0] stamp_arr [NUM_MB];

    // acceptance and selection
    logic [NUM_MB-1:0] cand, storable, pick_grant, pend_q, lost_q;
    logic              pick_any;

    rxmb_accept #(.NUM_MB(NUM_MB)) u_accept (
        .rx_valid (rx_valid),
        .rx_id    (rx_id),
        .enable   (en_q),
        .dir_rx   (dir_q),
        .mb_id    (id_arr),
        .mb_mask  (mask_arr),
        .cand     (cand)
    );

    assign storable = cand & (~pend_q | ~prot_q);

    rxmb_pick #(.NUM_MB(NUM_MB)) u_pick (
        .req   (storable),
        .grant (pick_grant),
        .any   (pick_any)
    );

    rxmb_flags #(.NUM_MB(NUM_MB)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .store_en (pick_any),
        .grant    (pick_grant),
        .protect  (prot_q),
        .pend_clr (pend_clr),
        .lost_clr (lost_clr),
        .pending  (pend_q),
        .lost     (lost_q)
    );

    rx_frame_t frame_in;
    assign frame_in = '{id: rx_id, ctrl: rx_ctrl, data: rx_data};

    // per-mailbox words
    for (genvar g = 0; g < NUM_MB; g++) begin : g_mb
        logic [ID_W-1:0]   id_r;
        logic [ID_W-1:0]   mask_r;
        logic [CTRL_W-1:0] ctrl_r;
        logic [DATA_W-1:0] data_r;
        logic [TIME_W-1:0] stamp_r;
        logic              host_hit;
        logic              store_hit;

        assign host_hit  = host_wr && is_mb && (a_idx == IDX_W'(g));
        assign store_hit = pick_any && pick_grant[g];

        always_ff @(posedge clk) begin
            if (rst) begin
                id_r    <= '0;
                mask_r  <= '0;
                ctrl_r  <= '0;
                data_r  <= '0;
                stamp_r <= '0;
            end else if (store_hit) begin
                id_r    <= merge_id(id_r, frame_in.id);
                ctrl_r  <= frame_in.ctrl;
                data_r  <= frame_in.data;
                stamp_r <= now;
            end else if (host_hit) begin
                if (mfld == FLD_ID)   id_r   <= host_wdata;
                if (mfld == FLD_MASK) mask_r <= host_wdata;
            end
        end

        assign id_arr[g]    = id_r;
        assign mask_arr[g]  = mask_r;
        assign ctrl_arr[g]  = ctrl_r;
        assign data_arr[g]  = data_r;
        assign stamp_arr[g] = stamp_r;
    end

    // read path
    logic [REG_W-1:0] rd_val;

    always_comb begin
        rd_val = '0;
        if (is_mb) begin
            if (int'(a_idx) < NUM_MB) begin
                case (mfld)
                    FLD_ID:    rd_val = id_arr[a_idx];
                    FLD_MASK:  rd_val = mask_arr[a_idx];
                    FLD_CTRL:  rd_val = REG_W'(ctrl_arr[a_idx]);
                    FLD_DLO:   rd_val = data_arr[a_idx][DATA_W-1:REG_W];
                    FLD_DHI:   rd_val = data_arr[a_idx][REG_W-1:0];
                    FLD_STAMP: rd_val = REG_W'(stamp_arr[a_idx]);
                    default:   rd_val = '0;
                endcase
            end
        end else if (glob_hit) begin
            case (gfld)
                GR_ENABLE:  rd_val = REG_W'(en_q);
                GR_DIR:     rd_val = REG_W'(dir_q);
                GR_PROTECT: rd_val = REG_W'(prot_q);
                GR_PENDING: rd_val = REG_W'(pend_q);
                GR_LOST:    rd_val = REG_W'(lost_q);
                GR_TIME:    rd_val = REG_W'(now);
                default:    rd_val = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) host_rdata <= '0;
        else     host_rdata <= rd_val;
    end

endmodule

// File: rtl/rxmb_bank_chk.sv
module rxmb_bank_chk #(
    parameter int NUM_MB = 32,
    parameter int TIME_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_MB-1:0] grant,
    input logic [NUM_MB-1:0] storable,
    input logic [NUM_MB-1:0] pending,
    input logic [NUM_MB-1:0] lost,
    input logic [NUM_MB-1:0] protect,
    input logic [TIME_W-1:0] net_now
);
    // R3: at most one mailbox takes a frame
    a_r3_single_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R3/R4: the granted mailbox must be one that can store
    a_r4_grant_in_storable: assert property (@(posedge clk) disable iff (rst)
        (grant & ~storable) == '0);

    // R4: a protected unread mailbox is never chosen
    a_r4_protected_kept: assert property (@(posedge clk) disable iff (rst)
        (grant & pending & protect) == '0);

    // R7: a store leaves the pending bit set
    a_r7_store_sets_pending: assert property (@(posedge clk) disable iff (rst)
        (grant != '0) |=> ((pending & $past(grant)) == $past(grant)));

    // R7: lost never stands without pending
    a_r7_lost_within_pending: assert property (@(posedge clk) disable iff (rst)
        (lost & ~pending) == '0);

    // R5: overwrite of an unread unprotected mailbox flags the loss
    a_r5_lost_on_overwrite: assert property (@(posedge clk) disable iff (rst)
        ((grant & pending & ~protect) != '0) |=> ((lost & $past(grant)) != '0));

    // R8: time advances by one each cycle out of reset
    a_r8_time_step: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (net_now == TIME_W'($past(net_now) + 1'b1)));
endmodule

bind rxmb_bank rxmb_bank_chk #(.NUM_MB(NUM_MB), .TIME_W(TIME_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .grant    (pick_grant),
    .storable (storable),
    .pending  (pend_q),
    .lost     (lost_q),
    .protect  (prot_q),
    .net_now  (now)
);

// File: tb/rxmb_bank_tb_top.sv
module rxmb_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_valid = 1'b0;
    logic [31:0] rx_id = '0;
    logic [4:0]  rx_ctrl = '0;
    logic [63:0] rx_data = '0;
    logic [8:0]  host_addr = '0;
    logic        host_wr = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;

    always #2.5 clk = ~clk;

    rxmb_bank dut_i (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_id(rx_id),
        .rx_ctrl(rx_ctrl), .rx_data(rx_data), .host_addr(host_addr),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata)
    );

    // bench time reference: zero in reset, plus one per clock after
    logic [31:0] tb_time;
    always_ff @(posedge clk) begin
        if (rst) tb_time <= '0;
        else     tb_time <= tb_time + 1;
    end

    int n_checks = 0;
    int n_fail   = 0;

    // reference model
    logic [31:0] m_en = '0, m_dir = '0, m_prot = '0, m_pend = '0, m_lost = '0;
    logic [31:0] m_id [32];
    logic [31:0] m_mask [32];
    logic [4:0]  m_ctrl [32];
    logic [63:0] m_data [32];
    logic [31:0] m_stamp [32];

    function automatic logic [8:0] mb_addr(int i, int f);
        return 9'h100 | 9'(i * 8) | 9'(f);
    endfunction

    function automatic bit b_accept(int i, logic [31:0] rid);
        logic [31:0] care;
        care = 32'h9FFF_FFFF & (m_id[i][30] ? ~m_mask[i] : 32'hFFFF_FFFF);
        return ((m_id[i] ^ rid) & care) == 32'h0;
    endfunction

    function automatic int b_pick(logic [31:0] rid);
        for (int i = 31; i >= 0; i--) begin
            if (m_en[i] && m_dir[i] && b_accept(i, rid) && (!m_pend[i] || !m_prot[i]))
                return i;
        end
        return -1;
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic model_write(input logic [8:0] a, input logic [31:0] d);
        if (a[8]) begin
            if (a[2:0] == 3'd0) m_id[a[7:3]]   = d;
            if (a[2:0] == 3'd1) m_mask[a[7:3]] = d;
        end else if (a[7:3] == 5'd0) begin
            case (a[2:0])
                3'd0: m_en   = d;
                3'd1: m_dir  = d;
                3'd2: m_prot = d;
                3'd3: begin m_pend &= ~d; m_lost &= ~d; end
                3'd4: m_lost &= ~d;
                default: ;
            endcase
        end
    endtask

    task automatic model_store(input int i, input logic [31:0] rid, input logic [4:0] c,
                               input logic [63:0] d, input logic [31:0] t, input bit was_pend);
        if (was_pend && !m_prot[i]) m_lost[i] = 1'b1;
        m_pend[i]  = 1'b1;
        m_id[i]    = (m_id[i] & 32'h6000_0000) | (rid & 32'h9FFF_FFFF);
        m_ctrl[i]  = c;
        m_data[i]  = d;
        m_stamp[i] = t;
    endtask

    task automatic host_write(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        model_write(a, d);
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [8:0] a, output logic [31:0] v, output logic [31:0] t);
        @(negedge clk);
        host_addr = a;
        t = tb_time;
        @(negedge clk);
        v = host_rdata;
    endtask

    // frame alone, or frame plus a pending clear in the same cycle
    task automatic send(input logic [31:0] rid, input logic [4:0] c, input logic [63:0] d,
                        input logic [31:0] clr, output int tgt);
        bit was;
        @(negedge clk);
        rx_valid = 1'b1; rx_id = rid; rx_ctrl = c; rx_data = d;
        if (clr != 0) begin
            host_addr = 9'h003; host_wdata = clr; host_wr = 1'b1;
        end
        tgt = b_pick(rid);
        was = (tgt >= 0) ? m_pend[tgt] : 1'b0;
        if (clr != 0) model_write(9'h003, clr);
        if (tgt >= 0) model_store(tgt, rid, c, d, tb_time, was);
        @(negedge clk);
        rx_valid = 1'b0; host_wr = 1'b0;
    endtask

    task automatic check_flags(input string req);
        logic [31:0] v, t;
        host_read(9'h003, v, t); check({req, " pending"}, v, m_pend);
        host_read(9'h004, v, t); check({req, " lost"}, v, m_lost);
    endtask

    task automatic check_mb(input string req, input int i);
        logic [31:0] v, t;
        host_read(mb_addr(i, 0), v, t); check({req, " id"}, v, m_id[i]);
        host_read(mb_addr(i, 2), v, t); check({req, " R9 ctrl"}, v, {27'h0, m_ctrl[i]});
        host_read(mb_addr(i, 3), v, t); check({req, " R9 data lo"}, v, m_data[i][63:32]);
        host_read(mb_addr(i, 4), v, t); check({req, " R9 data hi"}, v, m_data[i][31:0]);
        host_read(mb_addr(i, 5), v, t); check({req, " R8 stamp"}, v, m_stamp[i]);
    endtask

    function automatic logic [31:0] std_id(int v);
        return 32'(v & 32'h7FF) << 18;
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog (all requirements): got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        logic [31:0] v, t;
        int tgt;
        for (int i = 0; i < 32; i++) begin
            m_id[i] = '0; m_mask[i] = '0; m_ctrl[i] = '0; m_data[i] = '0; m_stamp[i] = '0;
        end
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R11 reset state, R12 read latency
        host_read(9'h000, v, t); check("R11 enable", v, 32'h0);
        host_read(9'h003, v, t); check("R11 pending", v, 32'h0);
        host_read(9'h004, v, t); check("R11 lost", v, 32'h0);
        host_read(mb_addr(7, 0), v, t); check("R11 mb id", v, 32'h0);
        host_read(mb_addr(7, 5), v, t); check("R11 mb stamp", v, 32'h0);
        host_read(9'h007, v, t); check("R12 unmapped", v, 32'h0);
        // R8 time read
        host_read(9'h005, v, t); check("R8 time", v, t);
        host_read(9'h005, v, t); check("R8 time later", v, t);

        // directed configuration
        host_write(mb_addr(9, 0), std_id(12'h123));               // exact
        host_write(mb_addr(8, 0), 32'h4000_0000 | std_id(12'h120));
        host_write(mb_addr(8, 1), (32'hF << 18) | 32'h3FFFF);      // low 4 bits don't care
        host_write(mb_addr(5, 0), std_id(12'h555));               // transmit direction
        host_write(mb_addr(3, 0), std_id(12'h333));               // disabled
        host_write(9'h000, 32'h0000_0320);                        // enable 9,8,5
        host_write(9'h001, 32'h0000_0308);                        // receive 9,8,3
        host_write(9'h002, 32'h0000_0200);                        // protect 9
        host_read(mb_addr(8, 1), v, t); check("R2 mask readback", v, m_mask[8]);

        send(std_id(12'h555), 5'd8, 64'h1111_2222_3333_4444, 0, tgt);
        check_flags("R1 transmit mailbox ignored");
        send(std_id(12'h333), 5'd8, 64'h1, 0, tgt);
        check_flags("R1 disabled mailbox ignored");
        send(std_id(12'h7FF), 5'd8, 64'h2, 0, tgt);
        check_flags("R6 no match dropped");
        check_mb("R6 mailbox untouched", 8);

        send(std_id(12'h123), 5'h18, 64'h0102_0304_0506_0708, 0, tgt);
        check("R3 highest taken", 32'(tgt), 32'd9);
        check_flags("R3 pending set");
        check_mb("R3", 9);
        send(std_id(12'h12A), 5'd3, 64'hAABB_CCDD_EEFF_0011, 0, tgt);
        check_flags("R2 masked accept");
        check_mb("R2", 8);
        send(std_id(12'h123), 5'd5, 64'h5555_6666_7777_8888, 0, tgt);
        check("R4 protected skipped", 32'(tgt), 32'd8);
        check_flags("R5 overwrite lost");
        check_mb("R4", 9);
        check_mb("R5", 8);

        host_write(9'h004, 32'h0000_0100);
        check_flags("R7 lost write-one clear");
        send(std_id(12'h121), 5'd1, 64'h9, 0, tgt);
        check_flags("R5 lost again");
        host_write(9'h003, 32'h0000_0100);
        check_flags("R7 pending clear takes lost");
        host_write(9'h003, 32'h0000_0000);
        check_flags("R7 zero write no effect");
        // extended frame vs exact std mailbox: no match
        send(32'h8000_0000 | std_id(12'h123), 5'd2, 64'h7, 32'h0000_0200, tgt);
        check_flags("R10 clear with dropped frame");
        // store and clear on the same mailbox
        send(std_id(12'h124), 5'd2, 64'h77, 32'h0000_0100, tgt);
        send(std_id(12'h124), 5'd4, 64'h78, 32'h0000_0100, tgt);
        check_flags("R10 store beats clear");
        check_mb("R10", 8);

        // chained FIFO on mailboxes 16..31
        host_write(9'h003, 32'hFFFF_FFFF);
        host_write(9'h004, 32'hFFFF_FFFF);
        for (int i = 16; i < 32; i++) begin
            host_write(mb_addr(i, 0), 32'h4000_0000);
            host_write(mb_addr(i, 1), 32'hFFFF_FFFF);
        end
        host_write(9'h000, 32'hFFFF_FFFF);
        host_write(9'h001, 32'hFFFF_0000);
        host_write(9'h002, 32'hFFFE_0000);
        check_flags("R4 fifo start");

        for (int k = 0; k < 400; k++) begin
            int r;
            logic [31:0] rid, clr;
            logic [63:0] d;
            r   = $urandom_range(0, 9);
            rid = $urandom;
            d   = {$urandom, $urandom};
            if (r < 6) begin
                send(rid, 5'($urandom), d, 0, tgt);
                check_flags("R4/R5 fifo frame");
                if (tgt >= 0 && (k % 4) == 0) check_mb("R3/R9 fifo", tgt);
            end else if (r < 8) begin
                clr = $urandom & $urandom;
                host_write(9'h003, clr);
                check_flags("R7 random clear");
            end else begin
                clr = 32'hFFFF_0000 & ($urandom | (32'h1 << (16 + $urandom_range(0, 15))));
                send(rid, 5'($urandom), d, clr, tgt);
                check_flags("R10 random same cycle");
                if (tgt >= 0) check_mb("R10 fifo", tgt);
            end
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule